// File: doc/BRIEF.md
# Audio Effects Multiply-Accumulate Core

This block is the arithmetic heart of a microprogrammed audio effects processor that runs a program of 128 steps for every audio sample frame. On each accepted step it takes the decoded fields of the current microinstruction, chooses one 24-bit signed input from three input banks, forms the three operands of a multiply-add, and registers the next 26-bit two's-complement accumulator value. The multiplier operand X is either the chosen input or a word read from a 128-entry temporary ring. The multiplicand Y comes from one of four sources: a fraction register, the coefficient that belongs to the current step, or a high or low slice of a Y register. The addend B is the previous accumulator or a temporary-ring word, optionally negated, or it is dropped entirely.

Temporary-ring reads are not made at the raw instruction offset: a per-frame countdown pointer is added to it, so the same program walks through the ring by one position each frame. The pointer runs from the ring length down to 1 and then reloads. A step counter supplies the coefficient address and produces a one-cycle pulse when the last step of a frame has been taken. The register banks, the temporary ring and the coefficient store live outside the block and are read through combinational index/data ports; the output shifter, external sample memory and microcode store are not part of it.

Top module: `amac_core`

## Requirements
- R1: The input select code chooses the 24-bit input as follows: codes 0 to 31 give memory bank entry [code] unchanged; codes 32 to 47 give mix entry [code-32] (20-bit signed) multiplied by 16; code 48 gives external input 0 (16-bit signed) multiplied by 256; code 49 gives external input 1 multiplied by 256; codes 50 to 63 give zero.
- R2: On an accepted step with the Y-latch bit set, the Y register takes the chosen input; with the bit clear, and on every cycle without an accepted step, it keeps its value (apart from the frame-start clear of R8).
- R3: The temporary-ring read index is (ring offset field + ring pointer) modulo 128.
- R4: Unless the zero flag is set, B is the accumulator when the B-select bit is 1 and the sign-extended temporary word when it is 0; with the negate flag set, B is replaced by its two's-complement negative.
- R5: X is the chosen input when the X-select bit is 1 and the temporary word when it is 0.
- R6: Y-select 0 gives the fraction register; 1 gives the step's 16-bit coefficient divided by 8 rounding toward minus infinity (13-bit signed); 2 gives the Y register divided by 2048 rounding toward minus infinity (13-bit signed); 3 gives bits 15 to 4 of the Y register as a non-negative 12-bit value.
- R7: After an accepted step the accumulator equals floor(X*Y / 4096) plus B, taken modulo 2^26 as a signed value; with the zero flag set B contributes nothing.
- R8: On step 0 of each frame the accumulator, the Y register and the fraction register read as zero for that step's operands; reset also clears the accumulator and Y register.
- R9: The step index starts at 0, advances by one on each accepted step, returns to 0 after step 127 and is otherwise held; the frame-done output is high for exactly the one cycle after step 127 is accepted.
- R10: The ring pointer resets to the ring length, decrements by one after step 127 is accepted, reloads the ring length when it would reach 0, and never changes at any other time.
- R11: The coefficient read index equals the current step index.
- R12: On an accepted step with the fraction-write input high, the fraction register takes the 13-bit write value for use from the next step on; otherwise it holds (apart from R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| step_valid | input | 1 | Current step is accepted at this edge |
| f_ira | input | 6 | Input select code |
| f_xsel | input | 1 | X from chosen input (1) or temporary word (0) |
| f_yrl | input | 1 | Load Y register with chosen input |
| f_zero | input | 1 | Drop B from the sum |
| f_bsel | input | 1 | B from accumulator (1) or temporary word (0) |
| f_negb | input | 1 | Negate B |
| f_tra | input | 7 | Temporary-ring offset |
| f_ysel | input | 2 | Y source select |
| frc_wr | input | 1 | Write fraction register on this step |
| frc_wdata | input | 13 | Fraction register write value |
| mems_idx | output | 5 | Memory-input bank read index |
| mems_data | input | 24 | Memory-input bank read data |
| mixs_idx | output | 4 | Mix bank read index |
| mixs_data | input | 20 | Mix bank read data |
| ext0_data | input | 16 | External input 0 |
| ext1_data | input | 16 | External input 1 |
| tmp_idx | output | 7 | Temporary-ring read index |
| tmp_data | input | 24 | Temporary-ring read data |
| coef_idx | output | log2(STEPS) | Coefficient read index |
| coef_data | input | 16 | Coefficient read data |
| step_idx | output | log2(STEPS) | Current step index |
| ring_pos | output | RW | Ring pointer, RW = ceil(log2(RING_LEN+1)) |
| acc | output | 26 | Accumulator |
| yreg | output | 24 | Y register |
| frame_done | output | 1 | One-cycle pulse after the last step |

## Verification
The core is driven through four whole frames with a short ring length so that the pointer both counts down and reloads, which separates a correct modulo-128 ring index from one that ignores the pointer or misses the reload. A directed opening walks the input select code across every range boundary (31/32, 47/48, 49/50, 63) with the Y latch set, so the Y register shows each scaled input exactly and a wrong shift amount or boundary is visible at once. The rest of the frames use pseudo-random fields and data with negative values in every bank, so floor versus truncating division in the scale-down and Y slicing, the unsigned low slice against the signed high slice, negated versus plain B and the 26-bit wrap of a growing accumulator all produce different accumulator values. Idle cycles are scattered among the steps to show that nothing moves without an accepted step.

// File: rtl/amac_pkg.sv
package amac_pkg;

  localparam int IN_W    = 24;
  localparam int ACC_W   = 26;
  localparam int Y_W     = 13;
  localparam int MIX_W   = 20;
  localparam int EXT_W   = 16;
  localparam int COEF_W  = 16;
  localparam int SCALE   = 12;
  localparam int TMP_AW  = 7;
  localparam int SEL_W   = 6;
  localparam int MEMS_N  = 32;
  localparam int MIXS_N  = 16;
  localparam int MEMS_AW = $clog2(MEMS_N);
  localparam int MIXS_AW = $clog2(MIXS_N);
  localparam int PROD_W  = IN_W + Y_W;
  localparam int MIX_SH  = IN_W - MIX_W;
  localparam int EXT_SH  = IN_W - EXT_W;
  localparam int LOW_HI  = 15;
  localparam int LOW_LO  = 4;

  localparam logic [SEL_W-1:0] SEL_MIX0 = SEL_W'(MEMS_N);
  localparam logic [SEL_W-1:0] SEL_EXT0 = SEL_W'(MEMS_N + MIXS_N);
  localparam logic [SEL_W-1:0] SEL_EXT1 = SEL_W'(MEMS_N + MIXS_N + 1);

  typedef enum logic [1:0] {
    Y_FRC  = 2'd0,
    Y_COEF = 2'd1,
    Y_HIGH = 2'd2,
    Y_LOW  = 2'd3
  } ysrc_e;

  // Input bank choice with the per-bank scaling.
  function automatic logic [IN_W-1:0] input_pick(
    input logic [SEL_W-1:0] sel,
    input logic [IN_W-1:0]  mems,
    input logic [MIX_W-1:0] mixs,
    input logic [EXT_W-1:0] e0,
    input logic [EXT_W-1:0] e1
  );
    logic [IN_W-1:0] r;
    r = '0;
    if (sel < SEL_MIX0)       r = mems;
    else if (sel < SEL_EXT0)  r = {mixs, {MIX_SH{1'b0}}};
    else if (sel == SEL_EXT0) r = {e0, {EXT_SH{1'b0}}};
    else if (sel == SEL_EXT1) r = {e1, {EXT_SH{1'b0}}};
    return r;
  endfunction

  // Y source slicing.
  function automatic logic [Y_W-1:0] y_pick(
    input ysrc_e            s,
    input logic [Y_W-1:0]   frc,
    input logic [COEF_W-1:0] coef,
    input logic [IN_W-1:0]  yr
  );
    logic [Y_W-1:0] r;
    unique case (s)
      Y_FRC:   r = frc;
      Y_COEF:  r = coef[COEF_W-1 -: Y_W];
      Y_HIGH:  r = yr[IN_W-1 -: Y_W];
      default: r = {1'b0, yr[LOW_HI:LOW_LO]};
    endcase
    return r;
  endfunction

  // Signed product at full width, scaled down, cut to accumulator width.
  function automatic logic [ACC_W-1:0] mac_scale(
    input logic [IN_W-1:0] x,
    input logic [Y_W-1:0]  y
  );
    logic signed [PROD_W-1:0] xe;
    logic signed [PROD_W-1:0] ye;
    logic signed [PROD_W-1:0] p;
    xe = {{(PROD_W-IN_W){x[IN_W-1]}}, x};
    ye = {{(PROD_W-Y_W){y[Y_W-1]}}, y};
    p  = xe * ye;
    p  = p >>> SCALE;
    return p[ACC_W-1:0];
  endfunction

  // Addend formation.
  function automatic logic [ACC_W-1:0] b_form(
    input logic [ACC_W-1:0] acc,
    input logic [IN_W-1:0]  tmp,
    input logic             bsel,
    input logic             negb,
    input logic             zero
  );
    logic [ACC_W-1:0] r;
    r = bsel ? acc : {{(ACC_W-IN_W){tmp[IN_W-1]}}, tmp};
    if (negb) r = -r;
    if (zero) r = '0;
    return r;
  endfunction

endpackage

// File: rtl/amac_seq.sv
module amac_seq #(
  parameter int STEPS    = 128,
  parameter int RING_LEN = 64,
  localparam int SW = $clog2(STEPS),
  localparam int RW = $clog2(RING_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_valid,
  output logic [SW-1:0] step_q,
  output logic [RW-1:0] ring_q,
  output logic          done_q,
  output logic          frame_start,
  output logic          last_step
);

  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  assign frame_start = (step_q == '0);
  assign last_step   = (step_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      ring_q <= RW'(RING_LEN);
      done_q <= 1'b0;
    end else begin
      done_q <= step_valid && last_step;
      if (step_valid) begin
        step_q <= last_step ? '0 : step_q + 1'b1;
        if (last_step) begin
          ring_q <= (ring_q == RW'(1)) ? RW'(RING_LEN) : ring_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/amac_operand.sv
module amac_operand
  import amac_pkg::*;
#(
  parameter int RING_LEN = 64,
  localparam int RW = $clog2(RING_LEN + 1)
) (
  input  logic [SEL_W-1:0]   f_ira,
  input  logic               f_xsel,
  input  logic               f_zero,
  input  logic               f_bsel,
  input  logic               f_negb,
  input  logic [TMP_AW-1:0]  f_tra,
  input  logic [1:0]         f_ysel,
  input  logic [RW-1:0]      ring_pos,
  input  logic [IN_W-1:0]    mems_data,
  input  logic [MIX_W-1:0]   mixs_data,
  input  logic [EXT_W-1:0]   ext0_data,
  input  logic [EXT_W-1:0]   ext1_data,
  input  logic [IN_W-1:0]    tmp_data,
  input  logic [COEF_W-1:0]  coef_data,
  input  logic [ACC_W-1:0]   acc_eff,
  input  logic [IN_W-1:0]    yreg_eff,
  input  logic [Y_W-1:0]     frc_eff,
  output logic [MEMS_AW-1:0] mems_idx,
  output logic [MIXS_AW-1:0] mixs_idx,
  output logic [TMP_AW-1:0]  tmp_idx,
  output logic [IN_W-1:0]    sel_in,
  output logic [ACC_W-1:0]   b_op,
  output logic [IN_W-1:0]    x_op,
  output logic [Y_W-1:0]     y_op
);

  logic [TMP_AW-1:0] ring_lo;

  generate
    if (RW >= TMP_AW) begin : g_ring_cut
      assign ring_lo = ring_pos[TMP_AW-1:0];
    end else begin : g_ring_ext
      assign ring_lo = {{(TMP_AW-RW){1'b0}}, ring_pos};
    end
  endgenerate

  assign mems_idx = f_ira[MEMS_AW-1:0];
  assign mixs_idx = f_ira[MIXS_AW-1:0];
  assign tmp_idx  = f_tra + ring_lo;

  assign sel_in = input_pick(f_ira, mems_data, mixs_data, ext0_data, ext1_data);
  assign b_op   = b_form(acc_eff, tmp_data, f_bsel, f_negb, f_zero);
  assign x_op   = f_xsel ? sel_in : tmp_data;
  assign y_op   = y_pick(ysrc_e'(f_ysel), frc_eff, coef_data, yreg_eff);

endmodule

// File: rtl/amac_accum.sv
module amac_accum
  import amac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic             frame_start,
  input  logic             f_yrl,
  input  logic             frc_wr,
  input  logic [Y_W-1:0]   frc_wdata,
  input  logic [IN_W-1:0]  sel_in,
  input  logic [IN_W-1:0]  x_op,
  input  logic [Y_W-1:0]   y_op,
  input  logic [ACC_W-1:0] b_op,
  output logic [ACC_W-1:0] acc_q,
  output logic [IN_W-1:0]  yreg_q,
  output logic [ACC_W-1:0] acc_eff,
  output logic [IN_W-1:0]  yreg_eff,
  output logic [Y_W-1:0]   frc_eff,
  output logic [ACC_W-1:0] prod_sh
);

  logic [Y_W-1:0]   frc_q;
  logic [ACC_W-1:0] acc_nxt;

  // Frame-start view: the registers read as cleared on step 0.
  assign acc_eff  = frame_start ? '0 : acc_q;
  assign yreg_eff = frame_start ? '0 : yreg_q;
  assign frc_eff  = frame_start ? '0 : frc_q;

  assign prod_sh = mac_scale(x_op, y_op);
  assign acc_nxt = prod_sh + b_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      yreg_q <= '0;
      frc_q  <= '0;
    end else if (step_valid) begin
      acc_q  <= acc_nxt;
      yreg_q <= f_yrl  ? sel_in    : yreg_eff;
      frc_q  <= frc_wr ? frc_wdata : frc_eff;
    end
  end

endmodule

// File: rtl/amac_core.sv
module amac_core
  import amac_pkg::*;
#(
  parameter int STEPS    = 128,
  parameter int RING_LEN = 64,
  localparam int SW = $clog2(STEPS),
  localparam int RW = $clog2(RING_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_valid,
  input  logic [SEL_W-1:0]   f_ira,
  input  logic               f_xsel,
  input  logic               f_yrl,
  input  logic               f_zero,
  input  logic               f_bsel,
  input  logic               f_negb,
  input  logic [TMP_AW-1:0]  f_tra,
  input  logic [1:0]         f_ysel,
  input  logic               frc_wr,
  input  logic [Y_W-1:0]     frc_wdata,
  output logic [MEMS_AW-1:0] mems_idx,
  input  logic [IN_W-1:0]    mems_data,
  output logic [MIXS_AW-1:0] mixs_idx,
  input  logic [MIX_W-1:0]   mixs_data,
  input  logic [EXT_W-1:0]   ext0_data,
  input  logic [EXT_W-1:0]   ext1_data,
  output logic [TMP_AW-1:0]  tmp_idx,
  input  logic [IN_W-1:0]    tmp_data,
  output logic [SW-1:0]      coef_idx,
  input  logic [COEF_W-1:0]  coef_data,
  output logic [SW-1:0]      step_idx,
  output logic [RW-1:0]      ring_pos,
  output logic [ACC_W-1:0]   acc,
  output logic [IN_W-1:0]    yreg,
  output logic               frame_done
);

  // Named internal events used by the checker.
  logic             frame_start;
  logic             last_step;
  logic [IN_W-1:0]  sel_in;
  logic [ACC_W-1:0] b_op;
  logic [IN_W-1:0]  x_op;
  logic [Y_W-1:0]   y_op;
  logic [ACC_W-1:0] acc_eff;
  logic [IN_W-1:0]  yreg_eff;
  logic [Y_W-1:0]   frc_eff;
  logic [ACC_W-1:0] prod_sh;

  amac_seq #(
    .STEPS    (STEPS),
    .RING_LEN (RING_LEN)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_valid  (step_valid),
    .step_q      (step_idx),
    .ring_q      (ring_pos),
    .done_q      (frame_done),
    .frame_start (frame_start),
    .last_step   (last_step)
  );

  amac_operand #(
    .RING_LEN (RING_LEN)
  ) opnd_i (
    .f_ira     (f_ira),
    .f_xsel    (f_xsel),
    .f_zero    (f_zero),
    .f_bsel    (f_bsel),
    .f_negb    (f_negb),
    .f_tra     (f_tra),
    .f_ysel    (f_ysel),
    .ring_pos  (ring_pos),
    .mems_data (mems_data),
    .mixs_data (mixs_data),
    .ext0_data (ext0_data),
    .ext1_data (ext1_data),
    .tmp_data  (tmp_data),
    .coef_data (coef_data),
    .acc_eff   (acc_eff),
    .yreg_eff  (yreg_eff),
    .frc_eff   (frc_eff),
    .mems_idx  (mems_idx),
    .mixs_idx  (mixs_idx),
    .tmp_idx   (tmp_idx),
    .sel_in    (sel_in),
    .b_op      (b_op),
    .x_op      (x_op),
    .y_op      (y_op)
  );

  amac_accum accum_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_valid  (step_valid),
    .frame_start (frame_start),
    .f_yrl       (f_yrl),
    .frc_wr      (frc_wr),
    .frc_wdata   (frc_wdata),
    .sel_in      (sel_in),
    .x_op        (x_op),
    .y_op        (y_op),
    .b_op        (b_op),
    .acc_q       (acc),
    .yreg_q      (yreg),
    .acc_eff     (acc_eff),
    .yreg_eff    (yreg_eff),
    .frc_eff     (frc_eff),
    .prod_sh     (prod_sh)
  );

  assign coef_idx = step_idx;

endmodule

// File: rtl/amac_checker.sv
module amac_checker
  import amac_pkg::*;
#(
  parameter int STEPS    = 128,
  parameter int RING_LEN = 64,
  localparam int SW = $clog2(STEPS),
  localparam int RW = $clog2(RING_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_valid,
  input logic             f_zero,
  input logic             f_bsel,
  input logic             f_yrl,
  input logic [SW-1:0]    step_idx,
  input logic [RW-1:0]    ring_pos,
  input logic             frame_done,
  input logic [ACC_W-1:0] acc,
  input logic [IN_W-1:0]  yreg,
  input logic [IN_W-1:0]  sel_in,
  input logic [ACC_W-1:0] b_op,
  input logic [ACC_W-1:0] prod_sh
);

  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  a_r9_step_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_idx != LAST) |=> (step_idx == $past(step_idx) + 1'b1));

  a_r9_wrap_done: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_idx == LAST) |=> (step_idx == '0 && frame_done));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> ($stable(step_idx) && !frame_done));

  a_r2_idle_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> ($stable(yreg) && $stable(acc)));

  a_r2_yload: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && f_yrl) |=> (yreg == $past(sel_in)));

  a_r7_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && f_zero) |=> (acc == $past(prod_sh)));

  a_r8_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx == '0 && !f_zero && f_bsel) |-> (b_op == '0));

  a_r10_ring_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_pos != '0) && (int'(ring_pos) <= RING_LEN));

  a_r10_ring_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_valid && step_idx == LAST) |=> $stable(ring_pos));

endmodule

bind amac_core amac_checker #(
  .STEPS    (STEPS),
  .RING_LEN (RING_LEN)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_valid (step_valid),
  .f_zero     (f_zero),
  .f_bsel     (f_bsel),
  .f_yrl      (f_yrl),
  .step_idx   (step_idx),
  .ring_pos   (ring_pos),
  .frame_done (frame_done),
  .acc        (acc),
  .yreg       (yreg),
  .sel_in     (sel_in),
  .b_op       (b_op),
  .prod_sh    (prod_sh)
);

// File: tb/amac_core_tb_top.sv
`timescale 1ns/1ps
module amac_core_tb_top;
  import amac_pkg::*;

  localparam int STEPS = 128;
  localparam int RL    = 3;
  localparam int SW    = $clog2(STEPS);
  localparam int RW    = $clog2(RL + 1);
  localparam int WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              step_valid = 1'b0;
  logic [5:0]        f_ira = '0;
  logic              f_xsel = 1'b0, f_yrl = 1'b0, f_zero = 1'b0, f_bsel = 1'b0, f_negb = 1'b0;
  logic [6:0]        f_tra = '0;
  logic [1:0]        f_ysel = '0;
  logic              frc_wr = 1'b0;
  logic [12:0]       frc_wdata = '0;
  logic [4:0]        mems_idx;
  logic [3:0]        mixs_idx;
  logic [6:0]        tmp_idx;
  logic [SW-1:0]     coef_idx, step_idx;
  logic [RW-1:0]     ring_pos;
  logic [25:0]       acc;
  logic [23:0]       yreg;
  logic              frame_done;

  logic [23:0] mems_m [32];
  logic [19:0] mixs_m [16];
  logic [23:0] tmp_m  [128];
  logic [15:0] coef_m [STEPS];
  logic [15:0] ext0 = 16'hA5C3;
  logic [15:0] ext1 = 16'h1234;

  amac_core #(.STEPS(STEPS), .RING_LEN(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid),
    .f_ira(f_ira), .f_xsel(f_xsel), .f_yrl(f_yrl), .f_zero(f_zero),
    .f_bsel(f_bsel), .f_negb(f_negb), .f_tra(f_tra), .f_ysel(f_ysel),
    .frc_wr(frc_wr), .frc_wdata(frc_wdata),
    .mems_idx(mems_idx), .mems_data(mems_m[mems_idx]),
    .mixs_idx(mixs_idx), .mixs_data(mixs_m[mixs_idx]),
    .ext0_data(ext0), .ext1_data(ext1),
    .tmp_idx(tmp_idx), .tmp_data(tmp_m[tmp_idx]),
    .coef_idx(coef_idx), .coef_data(coef_m[coef_idx]),
    .step_idx(step_idx), .ring_pos(ring_pos),
    .acc(acc), .yreg(yreg), .frame_done(frame_done)
  );

  typedef struct {
    logic [25:0] acc;
    logic [23:0] yreg;
    int          step;
    int          ring;
    bit          done;
    bit          yrl;
    bit          first;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  longint m_acc = 0, m_y = 0, m_frc = 0;
  int     m_step = 0, m_ring = RL;
  logic [31:0] rs = 32'h1ACE5EED;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint sx(input longint v, input int w);
    longint r;
    r = v & ((64'sd1 <<< w) - 1);
    if (r >= (64'sd1 <<< (w - 1))) r = r - (64'sd1 <<< w);
    return r;
  endfunction

  function automatic longint fdiv(input longint a, input longint d);
    longint q;
    q = a / d;
    if ((a % d) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  task automatic rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
  endtask

  // Driver: entered at a falling edge, applies one step, pushes the expectation.
  task automatic do_step(input logic [5:0] ira, input bit xs, input bit yl, input bit zr,
                         input bit bs, input bit nb, input logic [6:0] tra,
                         input logic [1:0] ys, input bit fw, input logic [12:0] fd);
    longint a_e, y_e, fr_e, inp, tv, b, x, y, p;
    int ti;
    int cur;
    item_t it;
    bit first;
    first = (m_step == 0);
    cur   = m_step;
    a_e   = first ? 0 : m_acc;
    y_e   = first ? 0 : m_y;
    fr_e  = first ? 0 : m_frc;
    if (ira < 32)       inp = sx(mems_m[ira], 24);
    else if (ira < 48)  inp = sx(mixs_m[ira - 32], 20) * 16;
    else if (ira == 48) inp = sx(ext0, 16) * 256;
    else if (ira == 49) inp = sx(ext1, 16) * 256;
    else                inp = 0;
    ti = (int'(tra) + m_ring) % 128;
    tv = sx(tmp_m[ti], 24);
    b  = bs ? a_e : tv;
    if (nb) b = -b;
    if (zr) b = 0;
    x  = xs ? inp : tv;
    case (ys)
      2'd0:    y = fr_e;
      2'd1:    y = fdiv(sx(coef_m[cur], 16), 8);
      2'd2:    y = fdiv(y_e, 2048);
      default: y = (y_e >> 4) & 64'hFFF;
    endcase
    p = fdiv(x * y, 4096);
    m_acc = sx(p + b, 26);
    m_y   = yl ? inp : y_e;
    m_frc = fw ? sx(fd, 13) : fr_e;
    it.done  = (cur == STEPS - 1);
    m_step   = (cur + 1) % STEPS;
    if (it.done) m_ring = (m_ring == 1) ? RL : m_ring - 1;
    it.acc   = m_acc[25:0];
    it.yreg  = m_y[23:0];
    it.step  = m_step;
    it.ring  = m_ring;
    it.yrl   = yl;
    it.first = first;

    f_ira = ira; f_xsel = xs; f_yrl = yl; f_zero = zr; f_bsel = bs; f_negb = nb;
    f_tra = tra; f_ysel = ys; frc_wr = fw; frc_wdata = fd;
    step_valid = 1'b1;
    sb_q.push_back(it);
    #1;
    chk("R3 tmp index", tmp_idx, ti);
    chk("R11 coef index", coef_idx, cur);
    @(negedge clk);
  endtask

  task automatic idle();
    step_valid = 1'b0;
    frc_wr = 1'b0;
    @(negedge clk);
    chk("R9 step held", step_idx, m_step);
    chk("R9 no done", frame_done, 0);
    chk("R2 yreg held", yreg, m_y & 64'hFFFFFF);
    chk("R7 acc held", acc, m_acc & 64'h3FFFFFF);
  endtask

  // Monitor: pops one expectation per accepted step, just after the edge.
  always @(posedge clk) begin
    if (rst_n && step_valid) begin
      item_t it;
      #1;
      if (sb_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R9 unexpected result actual=%0d expected=%0d", 1, 0);
      end else begin
        it = sb_q.pop_front();
        if (it.first) chk("R8 R7 acc on frame start", acc, it.acc);
        else          chk("R7 R4 R5 R6 R12 acc", acc, it.acc);
        if (it.yrl)   chk("R1 R2 yreg load", yreg, it.yreg);
        else          chk("R2 yreg", yreg, it.yreg);
        chk("R9 step index", step_idx, it.step);
        chk("R9 frame done", frame_done, it.done);
        chk("R10 ring pointer", ring_pos, it.ring);
      end
    end
  end

  initial begin
    #(WATCHDOG_CYC * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] codes [8];
    int total;
    codes = '{6'h05, 6'h1F, 6'h20, 6'h2F, 6'h30, 6'h31, 6'h32, 6'h3F};
    for (int i = 0; i < 32; i++)    mems_m[i] = 24'((i * 32'h3A5B1) ^ 32'h00800123);
    for (int i = 0; i < 16; i++)    mixs_m[i] = 20'((i * 32'h13579) + 32'h8001);
    for (int i = 0; i < 128; i++)   tmp_m[i]  = 24'((i * 73 + 5) * 32'h2F1D);
    for (int i = 0; i < STEPS; i++) coef_m[i] = 16'((i * 32'h1F3) ^ 32'h8C00);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset acc", acc, 0);
    chk("R8 reset yreg", yreg, 0);
    chk("R9 reset step", step_idx, 0);
    chk("R9 reset done", frame_done, 0);
    chk("R10 reset ring", ring_pos, RL);

    // R1: walk the input select code across every range boundary.
    total = 0;
    for (int i = 0; i < 8; i++) begin
      do_step(codes[i], 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 7'(i * 9), 2'd2, 1'b0, 13'd0);
      total++;
    end

    while (total < 4 * STEPS) begin
      rnd();
      if (rs[31:27] == 5'd0) idle();
      rnd();
      do_step(rs[5:0], rs[6], rs[7], rs[8] & rs[9], rs[10], rs[11], rs[18:12],
              rs[20:19], rs[21], rs[31:22] ^ 13'h1A5B);
      total++;
    end
    idle();

    chk("R9 scoreboard drained", sb_q.size(), 0);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule